// File: doc/BRIEF.md
# PTP Time-of-Day Clock

This block keeps the time of day for precision time protocol hardware. A fractional accumulator counts in steps of 1/256 ns and advances by a programmable amount on every edge of the RTC clock. It holds exactly one second of time and then wraps. Each wrap adds one to a 48-bit seconds counter. The current time is driven straight out of the RTC domain as 48-bit seconds and 32-bit nanoseconds, so timestamping logic can sample it.

Control comes from a separate CPU clock domain through four independent request/acknowledge channels:
- a new per-cycle increment,
- a time load (seconds and nanoseconds together),
- a signed period adjustment that lasts a given number of RTC cycles,
- a time read that returns a coherent snapshot.

Increment plus adjustment is formed one cycle early in a registered pre-adder, so the accumulator path holds only one adder and one compare. A CPU polls `adj_done` to learn when an adjustment has run out.

Top module: `ptp_tod_clock`

## Requirements
- R1: Every RTC cycle the accumulator grows by the increment, in units of 1/256 ns. `tod_ns` equals the accumulator shifted right by 8.
- R2: The accumulator wraps at 256,000,000,000 units, and each wrap adds one to `tod_sec`. `tod_ns` is always below 1,000,000,000.
- R3: A low `rtc_rst_n` clears `tod_sec` and `tod_ns` to zero. It keeps the increment last programmed, and time resumes at that rate.
- R4: A load sets `tod_sec` and `tod_ns` to the written values and clears the fraction. A load with nanoseconds of 1,000,000,000 or more is ignored, and time runs on undisturbed.
- R5: An adjustment adds the signed `adj_val` (two's complement, `ADJ_W` bits) to the increment for exactly `adj_len` RTC cycles. Negative values such as -16 are accepted.
- R6: The effective step is clamped at zero. Apart from a load, time never moves backwards.
- R7: `adj_done` is low from the CPU cycle after an accepted `adj_wr` until the adjustment has run out, and high afterwards. An `adj_len` of zero leaves the rate unchanged and ends with `adj_done` high.
- R8: A `rd_req` is answered by a one-cycle `rd_ack`. With it, `rd_sec`/`rd_ns` hold a time captured between the request and the acknowledge.
- R9: A write to a channel whose previous command is still in flight is dropped. `cmd_busy` is high from an accepted write until the RTC domain has applied it.
- R10: A new increment changes the rate of time from then on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rtc_clk | input | 1 | RTC clock |
| rtc_rst_n | input | 1 | synchronous active-low reset, RTC domain |
| cpu_clk | input | 1 | CPU clock |
| cpu_rst_n | input | 1 | synchronous active-low reset, CPU domain |
| incr_wr | input | 1 | write strobe for a new increment |
| incr_val | input | INCR_W | increment per RTC cycle, 1/256 ns units |
| load_wr | input | 1 | write strobe for a time load |
| load_sec | input | 48 | seconds to load |
| load_ns | input | 32 | nanoseconds to load |
| adj_wr | input | 1 | write strobe for a period adjustment |
| adj_val | input | ADJ_W | signed adjustment added to the increment |
| adj_len | input | LEN_W | adjustment duration in RTC cycles |
| rd_req | input | 1 | time read request |
| cmd_busy | output | 1 | a write channel is still in flight |
| adj_done | output | 1 | no adjustment pending |
| rd_ack | output | 1 | one-cycle pulse: read data valid |
| rd_sec | output | 48 | snapshot seconds |
| rd_ns | output | 32 | snapshot nanoseconds |
| tod_sec | output | 48 | live seconds, RTC domain |
| tod_ns | output | 32 | live nanoseconds, RTC domain |

## Verification
The bench compares time against a model in 1/256 ns units, so it catches the following faults:
- an off-by-one wrap limit, which would let `tod_ns` reach a full second or skew seconds around the rollover;
- an adjustment window one cycle long or short, which shifts the measured time by one adjustment step;
- a negative adjustment larger than the increment without the clamp, which would wrap the step to a huge value and throw time forward;
- a reset that also clears the increment, which would stop time after reset;
- a range check missing from the load, which would load an invalid nanosecond value;
- a busy flag that does not guard its holding register, which would let a second write slip in.

Reads are issued repeatedly across a second boundary, so a snapshot torn between seconds and nanoseconds falls outside the request-to-acknowledge window.

// File: rtl/ptp_tod_pkg.sv
// Time format constants shared by the time-of-day clock.
// Assumes the fixed 1/256 ns fractional unit and a one-second modulo.
package ptp_tod_pkg;
    localparam int SEC_W  = 48;
    localparam int NS_W   = 32;
    localparam int FRAC_W = 8;
    localparam int ACC_W  = 38;
    localparam logic [ACC_W-1:0] ACC_MOD  = 38'd256_000_000_000;
    localparam logic [NS_W-1:0]  NS_LIMIT = 32'd1_000_000_000;
endpackage

// File: rtl/ptp_cdc_hs.sv
// Toggle request/acknowledge channel carrying one data word between clocks.
// The source holds the word stable while busy, and starts are dropped while busy.
// The toggles have no reset, so a reset on either side creates no stray pulse.
// The destination pulse is suppressed while the destination is in reset.
module ptp_cdc_hs #(
    parameter int W = 8
) (
    input  logic         src_clk,
    input  logic         src_rst_n,
    input  logic         src_start,
    input  logic [W-1:0] src_data,
    output logic         src_busy,
    output logic         src_done,
    input  logic         dst_clk,
    input  logic         dst_rst_n,
    output logic         dst_pulse,
    output logic [W-1:0] dst_data
);
    logic         req_tgl = 1'b0;
    logic [W-1:0] hold    = '0;
    logic         ack_s1 = 1'b0, ack_s2 = 1'b0, ack_s3 = 1'b0;
    logic         req_s1 = 1'b0, req_s2 = 1'b0, req_s3 = 1'b0;
    logic         accept;

    assign src_busy = req_tgl != ack_s2;
    assign src_done = ack_s2 != ack_s3;
    assign accept   = src_rst_n && src_start && !src_busy;

    // Capture the word and flip the request on an accepted start.
    always_ff @(posedge src_clk) begin
        if (accept) begin
            hold    <= src_data;
            req_tgl <= ~req_tgl;
        end
    end

    // Bring the acknowledge toggle back into the source domain.
    always_ff @(posedge src_clk) begin
        ack_s1 <= req_s3;
        ack_s2 <= ack_s1;
        ack_s3 <= ack_s2;
    end

    // Bring the request toggle into the destination domain.
    always_ff @(posedge dst_clk) begin
        req_s1 <= req_tgl;
        req_s2 <= req_s1;
        req_s3 <= req_s2;
    end

    assign dst_pulse = dst_rst_n && (req_s2 != req_s3);
    assign dst_data  = hold;

    // R9
    hold_stable_chk: assert property (@(posedge src_clk) disable iff (!src_rst_n)
        (src_start && src_busy) |=> $stable(hold));
    // R8
    pulse_single_chk: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
        dst_pulse |=> !dst_pulse);
    // R9
    done_idle_chk: assert property (@(posedge src_clk) disable iff (!src_rst_n)
        src_done |-> !src_busy);
endmodule

// File: rtl/ptp_tod_accum.sv
// RTC-domain time core: increment register, adjustment countdown,
// registered pre-adder and the modulo-one-second accumulator with seconds.
// Assumes the step is always far below the one-second modulo.
module ptp_tod_accum
    import ptp_tod_pkg::*;
#(
    parameter int          INCR_W     = 32,
    parameter int          ADJ_W      = 24,
    parameter int          LEN_W      = 32,
    parameter int unsigned INCR_RESET = 2560
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              incr_set,
    input  logic [INCR_W-1:0] incr_new,
    input  logic              load_set,
    input  logic [SEC_W-1:0]  load_sec,
    input  logic [NS_W-1:0]   load_ns,
    input  logic              adj_set,
    input  logic [ADJ_W-1:0]  adj_new,
    input  logic [LEN_W-1:0]  adj_len,
    output logic [SEC_W-1:0]  sec_o,
    output logic [NS_W-1:0]   ns_o,
    output logic              adj_done_o
);
    localparam int BIG_W  = (INCR_W > ADJ_W) ? INCR_W : ADJ_W;
    localparam int SUM_W  = BIG_W + 2;
    localparam int STEP_W = INCR_W + 1;

    logic [INCR_W-1:0]       incr_q = INCR_W'(INCR_RESET);
    logic signed [ADJ_W-1:0] adj_q;
    logic [LEN_W-1:0]        adj_left;
    logic                    adj_done_q;
    logic signed [SUM_W-1:0] step_sum;
    logic [STEP_W-1:0]       step_q;
    logic [ACC_W-1:0]        acc;
    logic [ACC_W:0]          acc_sum;
    logic [SEC_W-1:0]        sec_q;
    logic                    load_ok;

    // Programmed increment; reset deliberately leaves it alone.
    always_ff @(posedge clk) begin
        if (incr_set) incr_q <= incr_new;
    end

    // Adjustment value, remaining cycles and completion flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            adj_left   <= '0;
            adj_done_q <= 1'b1;
        end else if (adj_set) begin
            adj_q      <= adj_new;
            adj_left   <= adj_len;
            adj_done_q <= (adj_len == '0);
        end else if (adj_left != '0) begin
            adj_left <= adj_left - 1'b1;
            if (adj_left == LEN_W'(1)) adj_done_q <= 1'b1;
        end
    end

    // Pre-adder: next step from increment plus any live adjustment.
    always_comb begin
        step_sum = SUM_W'($signed({1'b0, incr_q}));
        if (adj_left != '0) step_sum = step_sum + SUM_W'(adj_q);
    end

    // Register the step, clamped at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)                step_q <= '0;
        else if (step_sum[SUM_W-1]) step_q <= '0;
        else                        step_q <= step_sum[STEP_W-1:0];
    end

    assign acc_sum = {1'b0, acc} + (ACC_W+1)'(step_q);
    assign load_ok = load_set && (load_ns < NS_LIMIT);

    // Accumulate, wrap once per second and count seconds.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc   <= '0;
            sec_q <= '0;
        end else if (load_ok) begin
            sec_q <= load_sec;
            acc   <= ACC_W'(load_ns) << FRAC_W;
        end else if (acc_sum >= {1'b0, ACC_MOD}) begin
            acc   <= ACC_W'(acc_sum - {1'b0, ACC_MOD});
            sec_q <= sec_q + 1'b1;
        end else begin
            acc <= acc_sum[ACC_W-1:0];
        end
    end

    assign sec_o      = sec_q;
    assign ns_o       = NS_W'(acc >> FRAC_W);
    assign adj_done_o = adj_done_q;

    // R2
    acc_mod_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc < ACC_MOD);
    // R2
    sec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_ok |=> (sec_q == $past(sec_q)) || (sec_q == $past(sec_q) + 1'b1));
    // R6
    time_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_ok |=> {sec_q, acc} >= $past({sec_q, acc}));
    // R5
    adj_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adj_left != '0 && !adj_set) |=> adj_left == $past(adj_left) - 1'b1);
    // R7
    adj_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adj_left != '0) |-> !adj_done_q);
endmodule

// File: rtl/ptp_tod_clock.sv
// Time-of-day clock top: CPU-domain command channels into the RTC core
// and a handshaked coherent time read back to the CPU domain.
// Assumes the CPU waits for cmd_busy low before reusing a write channel.
module ptp_tod_clock
    import ptp_tod_pkg::*;
#(
    parameter int          INCR_W     = 32,
    parameter int          ADJ_W      = 24,
    parameter int          LEN_W      = 32,
    parameter int unsigned INCR_RESET = 2560
) (
    input  logic              rtc_clk,
    input  logic              rtc_rst_n,
    input  logic              cpu_clk,
    input  logic              cpu_rst_n,
    input  logic              incr_wr,
    input  logic [INCR_W-1:0] incr_val,
    input  logic              load_wr,
    input  logic [47:0]       load_sec,
    input  logic [31:0]       load_ns,
    input  logic              adj_wr,
    input  logic [ADJ_W-1:0]  adj_val,
    input  logic [LEN_W-1:0]  adj_len,
    input  logic              rd_req,
    output logic              cmd_busy,
    output logic              adj_done,
    output logic              rd_ack,
    output logic [47:0]       rd_sec,
    output logic [31:0]       rd_ns,
    output logic [47:0]       tod_sec,
    output logic [31:0]       tod_ns
);
    localparam int LOAD_W = SEC_W + NS_W;
    localparam int ACMD_W = ADJ_W + LEN_W;

    logic [2:0]        wr_busy, wr_done;
    logic              incr_pulse, load_pulse, adj_pulse, rd_pulse;
    logic [INCR_W-1:0] incr_rtc;
    logic [LOAD_W-1:0] load_rtc;
    logic [ACMD_W-1:0] adj_rtc;
    logic              rd_flag, rd_busy, rd_done;
    logic              adj_done_rtc, done_s1, done_s2;
    logic [LOAD_W-1:0] snap = '0;

    ptp_cdc_hs #(.W(INCR_W)) u_incr_hs (
        .src_clk(cpu_clk), .src_rst_n(cpu_rst_n), .src_start(incr_wr),
        .src_data(incr_val), .src_busy(wr_busy[0]), .src_done(wr_done[0]),
        .dst_clk(rtc_clk), .dst_rst_n(rtc_rst_n), .dst_pulse(incr_pulse),
        .dst_data(incr_rtc));

    ptp_cdc_hs #(.W(LOAD_W)) u_load_hs (
        .src_clk(cpu_clk), .src_rst_n(cpu_rst_n), .src_start(load_wr),
        .src_data({load_sec, load_ns}), .src_busy(wr_busy[1]), .src_done(wr_done[1]),
        .dst_clk(rtc_clk), .dst_rst_n(rtc_rst_n), .dst_pulse(load_pulse),
        .dst_data(load_rtc));

    ptp_cdc_hs #(.W(ACMD_W)) u_adj_hs (
        .src_clk(cpu_clk), .src_rst_n(cpu_rst_n), .src_start(adj_wr),
        .src_data({adj_val, adj_len}), .src_busy(wr_busy[2]), .src_done(wr_done[2]),
        .dst_clk(rtc_clk), .dst_rst_n(rtc_rst_n), .dst_pulse(adj_pulse),
        .dst_data(adj_rtc));

    ptp_cdc_hs #(.W(1)) u_rd_hs (
        .src_clk(cpu_clk), .src_rst_n(cpu_rst_n), .src_start(rd_req),
        .src_data(1'b1), .src_busy(rd_busy), .src_done(rd_done),
        .dst_clk(rtc_clk), .dst_rst_n(rtc_rst_n), .dst_pulse(rd_pulse),
        .dst_data(rd_flag));

    ptp_tod_accum #(
        .INCR_W(INCR_W), .ADJ_W(ADJ_W), .LEN_W(LEN_W), .INCR_RESET(INCR_RESET)
    ) u_accum (
        .clk(rtc_clk), .rst_n(rtc_rst_n),
        .incr_set(incr_pulse), .incr_new(incr_rtc),
        .load_set(load_pulse), .load_sec(load_rtc[LOAD_W-1:NS_W]),
        .load_ns(load_rtc[NS_W-1:0]),
        .adj_set(adj_pulse), .adj_new(adj_rtc[ACMD_W-1:LEN_W]),
        .adj_len(adj_rtc[LEN_W-1:0]),
        .sec_o(tod_sec), .ns_o(tod_ns), .adj_done_o(adj_done_rtc));

    assign cmd_busy = |wr_busy;

    // Freeze seconds and nanoseconds together when a read reaches the RTC side.
    always_ff @(posedge rtc_clk) begin
        if (rd_pulse && rd_flag) snap <= {tod_sec, tod_ns};
    end

    // Take the frozen snapshot into the CPU domain once its acknowledge returns.
    always_ff @(posedge cpu_clk) begin
        if (!cpu_rst_n) begin
            rd_ack <= 1'b0;
            rd_sec <= '0;
            rd_ns  <= '0;
        end else begin
            rd_ack <= rd_done;
            if (rd_done) {rd_sec, rd_ns} <= snap;
        end
    end

    // Synchronise the completion flag into the CPU domain.
    always_ff @(posedge cpu_clk) begin
        if (!cpu_rst_n) begin
            done_s1 <= 1'b0;
            done_s2 <= 1'b0;
        end else begin
            done_s1 <= adj_done_rtc;
            done_s2 <= done_s1;
        end
    end

    assign adj_done = done_s2 && !wr_busy[2];

    // R8
    rd_ack_pulse_chk: assert property (@(posedge cpu_clk) disable iff (!cpu_rst_n)
        rd_ack |=> !rd_ack);
    // R8
    rd_done_busy_chk: assert property (@(posedge cpu_clk) disable iff (!cpu_rst_n)
        rd_done |-> $past(rd_busy));

    for (genvar g = 0; g < 3; g++) begin : g_wr_chk
        // R9
        wr_done_busy_chk: assert property (@(posedge cpu_clk) disable iff (!cpu_rst_n)
            wr_done[g] |-> $past(wr_busy[g]));
    end
endmodule

// File: tb/test_ptp_tod_clock.sv
module test_ptp_tod_clock;
    localparam logic [127:0] MODU = 128'd256_000_000_000;

    logic        rtc_clk = 0, cpu_clk = 0;
    logic        rtc_rst_n = 0, cpu_rst_n = 0;
    logic        incr_wr = 0, load_wr = 0, adj_wr = 0, rd_req = 0;
    logic [31:0] incr_val = 0, load_ns = 0, adj_len = 0;
    logic [47:0] load_sec = 0;
    logic [23:0] adj_val = 0;
    logic        cmd_busy, adj_done, rd_ack;
    logic [47:0] rd_sec, tod_sec;
    logic [31:0] rd_ns, tod_ns;
    longint      cyc = 0;
    int          n_chk = 0, n_err = 0;

    ptp_tod_clock i_ptp_tod_clock (
        .rtc_clk, .rtc_rst_n, .cpu_clk, .cpu_rst_n, .incr_wr, .incr_val,
        .load_wr, .load_sec, .load_ns, .adj_wr, .adj_val, .adj_len, .rd_req,
        .cmd_busy, .adj_done, .rd_ack, .rd_sec, .rd_ns, .tod_sec, .tod_ns);

    always #5 rtc_clk = ~rtc_clk;
    always #7 cpu_clk = ~cpu_clk;
    always @(posedge rtc_clk) cyc <= cyc + 1;

    // {incr, load_sec, load_ns, wait cycles}
    localparam logic [127:0] VEC [4] = '{
        {32'd2560,   48'd5,          32'd999_999_500, 16'd200},
        {32'd2048,   48'd0,          32'd0,           16'd100},
        {32'd256000, 48'hFFFF_FFFF,  32'd999_900_000, 16'd300},
        {32'd3840,   48'd12345,      32'd500,         16'd50}
    };

    task automatic check(input bit ok, input string req, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [127:0] units(input logic [47:0] s, input logic [31:0] n);
        return 128'(s) * MODU + 128'(n) * 256;
    endfunction

    task automatic sample(output logic [47:0] s, output logic [31:0] n, output longint c);
        @(negedge rtc_clk);
        s = tod_sec; n = tod_ns; c = cyc;
    endtask

    task automatic wait_idle();
        int guard = 0;
        @(negedge cpu_clk);
        while (cmd_busy && guard < 200) begin @(negedge cpu_clk); guard++; end
    endtask

    task automatic wr_incr(input logic [31:0] v);
        @(negedge cpu_clk); incr_wr = 1; incr_val = v;
        @(negedge cpu_clk); incr_wr = 0;
        wait_idle();
    endtask

    task automatic wr_load(input logic [47:0] s, input logic [31:0] n);
        @(negedge cpu_clk); load_wr = 1; load_sec = s; load_ns = n;
        @(negedge cpu_clk); load_wr = 0;
        wait_idle();
    endtask

    // Compare a later sample against an earlier one plus a known unit delta.
    task automatic check_span(input string req, input logic [127:0] ua,
                              input logic [127:0] delta, input logic [47:0] sb,
                              input logic [31:0] nb);
        logic [127:0] ue;
        ue = ua + delta;
        check(nb == 32'((ue % MODU) / 256), req, "ns after span", nb, (ue % MODU) / 256);
        check(sb == 48'(ue / MODU), req, "sec after span", sb, ue / MODU);
    endtask

    task automatic adj_test(input string req, input logic [23:0] v, input logic [31:0] len,
                            input logic [127:0] base, input logic [127:0] removed,
                            input bit positive);
        logic [47:0] sa, sb; logic [31:0] na, nb; longint ca, cb; int guard;
        logic [127:0] d;
        sample(sa, na, ca);
        @(negedge cpu_clk); adj_wr = 1; adj_val = v; adj_len = len;
        @(negedge cpu_clk); adj_wr = 0;
        if (len != 0) check(adj_done == 1'b0, "R7", "adj_done while pending", adj_done, 0);
        guard = 0;
        while ((!adj_done || cmd_busy) && guard < 500) begin @(negedge cpu_clk); guard++; end
        check(adj_done == 1'b1, "R7", "adj_done after end", adj_done, 1);
        repeat (5) @(negedge rtc_clk);
        sample(sb, nb, cb);
        d = 128'(cb - ca) * base;
        d = positive ? d + removed : d - removed;
        check_span(req, units(sa, na), d, sb, nb);
        check(units(sb, nb) >= units(sa, na), "R6", "time not backwards",
              units(sb, nb), units(sa, na));
    endtask

    initial begin
        #2_000_000;
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [47:0] sa, sb, rs; logic [31:0] na, nb, rn; longint ca, cb;
        repeat (4) @(negedge cpu_clk);
        check(tod_sec == 0 && tod_ns == 0, "R3", "time in reset", {tod_sec, tod_ns}, 0);
        check(cmd_busy == 0 && rd_ack == 0, "R9", "idle after reset", {cmd_busy, rd_ack}, 0);
        rtc_rst_n = 1; cpu_rst_n = 1;
        repeat (4) @(negedge cpu_clk);

        // Table walk: rate, load and rollover (R1 R2 R4 R10)
        for (int i = 0; i < 4; i++) begin
            logic [31:0] vi; logic [47:0] vs; logic [31:0] vn; logic [15:0] vw;
            {vi, vs, vn, vw} = VEC[i];
            wr_incr(vi);
            wr_load(vs, vn);
            repeat (2) @(negedge rtc_clk);
            sample(sa, na, ca);
            check(sa == vs && na >= vn, "R4", "loaded time", {sa, na}, {vs, vn});
            repeat (int'(vw)) @(negedge rtc_clk);
            sample(sb, nb, cb);
            check(nb < 32'd1_000_000_000, "R2", "ns below one second", nb, 999_999_999);
            check_span("R1", units(sa, na), 128'(cb - ca) * vi, sb, nb);
        end
        // Entry 0 and 2 rolled over into the next second (R2)
        check(sb == 48'd12345, "R10", "last entry second", sb, 12345);

        // Reset keeps the programmed increment (R3)
        @(negedge rtc_clk); rtc_rst_n = 0;
        repeat (3) @(negedge rtc_clk);
        check(tod_sec == 0 && tod_ns == 0, "R3", "time cleared by reset", {tod_sec, tod_ns}, 0);
        rtc_rst_n = 1;
        repeat (3) @(negedge rtc_clk);
        sample(sa, na, ca);
        repeat (40) @(negedge rtc_clk);
        sample(sb, nb, cb);
        check_span("R3", units(sa, na), 128'(cb - ca) * 3840, sb, nb);

        // Out-of-range load ignored (R4)
        sample(sa, na, ca);
        wr_load(48'd777, 32'd1_000_000_000);
        sample(sb, nb, cb);
        check(sb != 48'd777, "R4", "bad load sec ignored", sb, 0);
        check_span("R4", units(sa, na), 128'(cb - ca) * 3840, sb, nb);

        // Second write while busy is dropped (R9)
        @(negedge cpu_clk); incr_wr = 1; incr_val = 32'd2560;
        @(negedge cpu_clk); incr_val = 32'd7680;
        check(cmd_busy == 1'b1, "R9", "busy after write", cmd_busy, 1);
        @(negedge cpu_clk); incr_wr = 0;
        wait_idle();
        wr_load(48'd100, 32'd0);
        sample(sa, na, ca);
        repeat (30) @(negedge rtc_clk);
        sample(sb, nb, cb);
        check_span("R9", units(sa, na), 128'(cb - ca) * 2560, sb, nb);

        // Adjustments (R5 R6 R7), all multiples of 256 units
        adj_test("R5", 24'd512, 32'd20, 2560, 128'd10240, 1);
        adj_test("R5", -24'sd16, 32'd32, 2560, 128'd512, 0);
        adj_test("R6", -24'sd3000, 32'd10, 2560, 128'd25600, 0);
        adj_test("R7", -24'sd16, 32'd0, 2560, 128'd0, 0);

        // Coherent reads across a second boundary (R8)
        wr_incr(32'd256000);
        wr_load(48'd41, 32'd999_995_000);
        for (int k = 0; k < 6; k++) begin
            int guard = 0;
            sample(sa, na, ca);
            @(negedge cpu_clk); rd_req = 1;
            @(negedge cpu_clk); rd_req = 0;
            while (!rd_ack && guard < 100) begin @(negedge cpu_clk); guard++; end
            rs = rd_sec; rn = rd_ns;
            check(rd_ack == 1'b1, "R8", "ack arrives", rd_ack, 1);
            sample(sb, nb, cb);
            check(units(rs, rn) >= units(sa, na) && units(rs, rn) <= units(sb, nb),
                  "R8", "snapshot in window", units(rs, rn), units(sa, na));
            @(negedge cpu_clk);
            check(rd_ack == 1'b0, "R8", "ack one cycle", rd_ack, 0);
        end
        check(rs == 48'd42, "R2", "read after rollover", rs, 42);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule